// File: doc/BRIEF.md
# Lane Alignment Sequencer

This block sits on the transmit side of a multi-gigabit serial converter link, just ahead of the 8b/10b encoder. Once the receiver reports code group synchronization, the block picks what the lane carries next. It can send an initial lane alignment sequence, a stream of user octets, or an alignment sequence that repeats without end for link-layer testing. In the user stream it replaces repeated frame-end octets with alignment control characters, so the receiver can check frame and multiframe boundaries. Every output octet carries a flag that tells the encoder to pick a control code.

The frame length and the number of frames per multiframe are parameters. Configuration (mode, repeat count, insertion disable) is captured only while the power-down input is high. The block then runs from those captured values until the next power-down. Output octets are registered, so each one appears one clock after the input octet it is derived from.

Top module: `lane_seq_ctrl`

## Requirements
- R1: While `pwdn_i` is high, the output is 0x00 with `ctrl_o` low, the sequencer sits in its waiting state, and mode, repeat count and disable are captured from the inputs. Changes to those inputs while `pwdn_i` is low have no effect.
- R2: On every clock edge where `sync_i` is sampled low, and on the edge where it is first sampled high, the next output is K28.5 (0xBC) with `ctrl_o` high.
- R3: In alignment sequence output, the multiframe index counts 0 to 3 and each multiframe holds L = OCT_PER_FRAME * FRAMES_PER_MF octets. Position 0 of every multiframe is K28.0 (0x1C), position L-1 is K28.3 (0x7C), and position 1 of multiframe 1 is K28.4 (0x9C), all flagged as control. Every other position passes `data_i`/`ctrl_i` through.
- R4: With mode 01 and a captured repeat count N, exactly N+1 four-multiframe sequences are sent back to back. User data follows at once, with octet positions continuing from the sequence.
- R5: Mode 11 repeats the alignment sequence for as long as sync holds and ignores the repeat count. Modes 00 and the reserved code 10 both go straight to user data.
- R6: In user data, a non-control octet at the last position of a frame that equals the input octet at the last position of the previous frame is sent as K28.7 (0xFC) with `ctrl_o` high. The comparison uses the original input value, and the first frame after entering user data has no predecessor.
- R7: When the replacement of R6 falls on the last octet of a multiframe, K28.3 (0x7C) is sent instead.
- R8: With the captured disable bit set, user octets pass through unchanged.
- R9: A loss of sync during the alignment sequence, the test mode or user data returns the block to waiting. After sync returns, the next sequence restarts from multiframe 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Octet clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwdn_i | input | 1 | Hold sequencer in reset and capture configuration |
| mode_i | input | 2 | 00 data only, 01 one alignment phase, 10 reserved, 11 endless test |
| rep_cnt_i | input | 8 | Extra alignment sequence repetitions |
| align_dis_i | input | 1 | Disable alignment character substitution |
| sync_i | input | 1 | High when code group synchronization is done |
| data_i | input | 8 | Incoming octet (configuration or user data) |
| ctrl_i | input | 1 | Incoming octet is a control character |
| data_o | output | 8 | Octet to the 8b/10b encoder |
| ctrl_o | output | 1 | Output octet is a control character |

## Verification
The bench walks a repeat count of one and checks that the second sequence is sent. A design that miscounts by one would drop into user data 32 octets early, or send a third sequence. It checks that a frame-end repeat is compared with the original input octet and not with the substituted character, which a design that stores its output would miss. It changes mode and disable inputs while running, which exposes a design that samples them outside power-down. It drops sync partway through a sequence to catch a multiframe index that is not cleared and would put K28.4 in the wrong multiframe.

// File: rtl/lane_seq_pkg.sv
package lane_seq_pkg;
  localparam logic [7:0] K28_0 = 8'h1C;
  localparam logic [7:0] K28_3 = 8'h7C;
  localparam logic [7:0] K28_4 = 8'h9C;
  localparam logic [7:0] K28_5 = 8'hBC;
  localparam logic [7:0] K28_7 = 8'hFC;

  localparam logic [1:0] MODE_DATA = 2'b00;
  localparam logic [1:0] MODE_ONCE = 2'b01;
  localparam logic [1:0] MODE_TEST = 2'b11;

  typedef enum logic [1:0] {
    ST_WAIT,
    ST_ILAS,
    ST_DATA,
    ST_TEST
  } seq_st_e;

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] rep;
    logic       dis;
  } seq_cfg_t;
endpackage

// File: rtl/lane_seq_cfg.sv
module lane_seq_cfg
  import lane_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwdn_i,
  input  logic [1:0] mode_i,
  input  logic [7:0] rep_cnt_i,
  input  logic       align_dis_i,
  output seq_cfg_t   cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_o <= '0;
    else if (pwdn_i) cfg_o <= '{mode: mode_i, rep: rep_cnt_i, dis: align_dis_i};
  end

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwdn_i |=> $stable(cfg_o)); // R1
endmodule

// File: rtl/lane_seq_cnt.sv
module lane_seq_cnt #(
  parameter int unsigned OCT_PER_FRAME = 2,
  parameter int unsigned FRAMES_PER_MF = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       ilas_i,
  output logic       frame_last_o,
  output logic       mf_first_o,
  output logic       mf_last_o,
  output logic       cfg_slot_o,
  output logic       seq_end_o,
  output logic [7:0] seq_cnt_o
);
  localparam int unsigned L  = OCT_PER_FRAME * FRAMES_PER_MF;
  localparam int unsigned PW = (L > 1) ? $clog2(L) : 1;
  localparam int unsigned FW = (OCT_PER_FRAME > 1) ? $clog2(OCT_PER_FRAME) : 1;
  localparam logic [PW-1:0] POS_LAST = PW'(L - 1);
  localparam logic [FW-1:0] OCT_LAST = FW'(OCT_PER_FRAME - 1);

  logic [PW-1:0] pos_q;
  logic [FW-1:0] oct_q;
  logic [1:0]    mf_q;

  assign frame_last_o = (oct_q == OCT_LAST);
  assign mf_first_o   = (pos_q == '0);
  assign mf_last_o    = (pos_q == POS_LAST);
  assign cfg_slot_o   = (mf_q == 2'd1) && (pos_q == PW'(1));
  assign seq_end_o    = mf_last_o && (mf_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0; oct_q <= '0; mf_q <= '0; seq_cnt_o <= '0;
    end else if (clr_i) begin
      pos_q <= '0; oct_q <= '0; mf_q <= '0; seq_cnt_o <= '0;
    end else begin
      oct_q <= frame_last_o ? '0 : oct_q + FW'(1);
      pos_q <= mf_last_o ? '0 : pos_q + PW'(1);
      if (mf_last_o) mf_q <= mf_q + 2'd1;
      if (ilas_i && seq_end_o) seq_cnt_o <= seq_cnt_o + 8'd1;
    end
  end

  AST_FRAME_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_first_o |-> (oct_q == '0)); // R3
endmodule

// File: rtl/lane_seq_fsm.sv
module lane_seq_fsm
  import lane_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwdn_i,
  input  logic       sync_i,
  input  seq_cfg_t   cfg_i,
  input  logic       seq_end_i,
  input  logic [7:0] seq_cnt_i,
  output seq_st_e    st_o
);
  seq_st_e st_d;

  always_comb begin
    st_d = st_o;
    if (pwdn_i || !sync_i) st_d = ST_WAIT;
    else begin
      unique case (st_o)
        ST_WAIT: begin
          if (cfg_i.mode == MODE_ONCE)      st_d = ST_ILAS;
          else if (cfg_i.mode == MODE_TEST) st_d = ST_TEST;
          else                              st_d = ST_DATA; // 00 and reserved 10
        end
        ST_ILAS: if (seq_end_i && seq_cnt_i == cfg_i.rep) st_d = ST_DATA;
        default: st_d = st_o;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_o <= ST_WAIT;
    else         st_o <= st_d;
  end

  AST_PDN_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwdn_i |=> st_o == ST_WAIT); // R1
  AST_NOSYNC_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> st_o == ST_WAIT); // R9
  AST_TEST_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_o == ST_TEST && sync_i && !pwdn_i) |=> st_o == ST_TEST); // R5
endmodule

// File: rtl/lane_seq_mux.sv
module lane_seq_mux
  import lane_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwdn_i,
  input  logic       sync_i,
  input  seq_st_e    st_i,
  input  logic       dis_i,
  input  logic       frame_last_i,
  input  logic       mf_first_i,
  input  logic       mf_last_i,
  input  logic       cfg_slot_i,
  input  logic [7:0] data_i,
  input  logic       ctrl_i,
  output logic [7:0] data_o,
  output logic       ctrl_o
);
  logic [7:0] prev_q;
  logic       prev_vld_q;
  logic [7:0] data_d;
  logic       ctrl_d;
  logic       live;

  assign live = !pwdn_i && sync_i;

  always_comb begin
    data_d = data_i;
    ctrl_d = ctrl_i;
    if (pwdn_i) begin
      data_d = '0; ctrl_d = 1'b0;
    end else if (!sync_i || st_i == ST_WAIT) begin
      data_d = K28_5; ctrl_d = 1'b1;
    end else if (st_i == ST_ILAS || st_i == ST_TEST) begin
      if (mf_first_i)      begin data_d = K28_0; ctrl_d = 1'b1; end
      else if (mf_last_i)  begin data_d = K28_3; ctrl_d = 1'b1; end
      else if (cfg_slot_i) begin data_d = K28_4; ctrl_d = 1'b1; end
    end else if (!dis_i && frame_last_i && prev_vld_q && !ctrl_i && data_i == prev_q) begin
      data_d = mf_last_i ? K28_3 : K28_7;
      ctrl_d = 1'b1;
    end
  end

  // previous frame-end octet, kept as received (not as substituted)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0; prev_vld_q <= 1'b0;
    end else if (live && st_i == ST_DATA) begin
      if (frame_last_i) begin
        prev_q <= data_i; prev_vld_q <= 1'b1;
      end
    end else begin
      prev_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0; ctrl_o <= 1'b0;
    end else begin
      data_o <= data_d; ctrl_o <= ctrl_d;
    end
  end

  AST_PDN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwdn_i |=> (data_o == 8'h00 && !ctrl_o)); // R1
  AST_WAIT_K285: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwdn_i && !sync_i) |=> (data_o == K28_5 && ctrl_o)); // R2
  AST_DIS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && st_i == ST_DATA && dis_i) |=> (data_o == $past(data_i) && ctrl_o == $past(ctrl_i))); // R8
endmodule

// File: rtl/lane_seq_ctrl.sv
module lane_seq_ctrl
  import lane_seq_pkg::*;
#(
  parameter int unsigned OCT_PER_FRAME = 2,
  parameter int unsigned FRAMES_PER_MF = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwdn_i,
  input  logic [1:0] mode_i,
  input  logic [7:0] rep_cnt_i,
  input  logic       align_dis_i,
  input  logic       sync_i,
  input  logic [7:0] data_i,
  input  logic       ctrl_i,
  output logic [7:0] data_o,
  output logic       ctrl_o
);
  seq_cfg_t   cfg;
  seq_st_e    st;
  logic       frame_last, mf_first, mf_last, cfg_slot, seq_end;
  logic [7:0] seq_cnt;
  logic       cnt_clr;

  assign cnt_clr = pwdn_i || !sync_i || st == ST_WAIT;

  lane_seq_cfg i_cfg (
    .clk_i, .rst_ni, .pwdn_i, .mode_i, .rep_cnt_i, .align_dis_i,
    .cfg_o (cfg)
  );

  lane_seq_cnt #(
    .OCT_PER_FRAME (OCT_PER_FRAME),
    .FRAMES_PER_MF (FRAMES_PER_MF)
  ) i_cnt (
    .clk_i, .rst_ni,
    .clr_i        (cnt_clr),
    .ilas_i       (st == ST_ILAS),
    .frame_last_o (frame_last),
    .mf_first_o   (mf_first),
    .mf_last_o    (mf_last),
    .cfg_slot_o   (cfg_slot),
    .seq_end_o    (seq_end),
    .seq_cnt_o    (seq_cnt)
  );

  lane_seq_fsm i_fsm (
    .clk_i, .rst_ni, .pwdn_i, .sync_i,
    .cfg_i     (cfg),
    .seq_end_i (seq_end),
    .seq_cnt_i (seq_cnt),
    .st_o      (st)
  );

  lane_seq_mux i_mux (
    .clk_i, .rst_ni, .pwdn_i, .sync_i,
    .st_i         (st),
    .dis_i        (cfg.dis),
    .frame_last_i (frame_last),
    .mf_first_i   (mf_first),
    .mf_last_i    (mf_last),
    .cfg_slot_i   (cfg_slot),
    .data_i, .ctrl_i, .data_o, .ctrl_o
  );
endmodule

// File: tb/test_lane_seq_ctrl.sv
`timescale 1ns/1ps
module test_lane_seq_ctrl;
  localparam int F = 2;
  localparam int K = 4;
  localparam int L = F * K;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pwdn_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [7:0] rep_cnt_i = 8'd0;
  logic       align_dis_i = 1'b0;
  logic       sync_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       ctrl_i = 1'b0;
  logic [7:0] data_o;
  logic       ctrl_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  lane_seq_ctrl #(.OCT_PER_FRAME(F), .FRAMES_PER_MF(K)) i_lane_seq_ctrl (
    .clk_i, .rst_ni, .pwdn_i, .mode_i, .rep_cnt_i, .align_dis_i,
    .sync_i, .data_i, .ctrl_i, .data_o, .ctrl_o
  );

  // {data_i, ctrl_i, expected data_o, expected ctrl_o}, starting at multiframe position 0
  localparam logic [17:0] DVEC [16] = '{
    {8'h11, 1'b0, 8'h11, 1'b0},  // R6 first frame, no predecessor
    {8'h22, 1'b0, 8'h22, 1'b0},
    {8'h33, 1'b0, 8'h33, 1'b0},
    {8'h22, 1'b0, 8'hFC, 1'b1},  // R6 repeat -> K28.7
    {8'h22, 1'b0, 8'h22, 1'b0},  // R6 frame start never replaced
    {8'h23, 1'b0, 8'h23, 1'b0},
    {8'h05, 1'b0, 8'h05, 1'b0},
    {8'h23, 1'b0, 8'h7C, 1'b1},  // R7 repeat at multiframe end -> K28.3
    {8'h23, 1'b0, 8'h23, 1'b0},
    {8'h24, 1'b0, 8'h24, 1'b0},
    {8'h00, 1'b0, 8'h00, 1'b0},
    {8'h24, 1'b0, 8'hFC, 1'b1},  // R6
    {8'h00, 1'b0, 8'h00, 1'b0},
    {8'h24, 1'b0, 8'hFC, 1'b1},  // R6 compares original octet
    {8'h77, 1'b0, 8'h77, 1'b0},
    {8'h24, 1'b1, 8'h24, 1'b1}   // R6 control input not replaced
  };

  task automatic tick(input logic [7:0] d, input logic k);
    data_i = d;
    ctrl_i = k;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input logic [7:0] ed, input logic ek, input string tag);
    checks++;
    if (data_o !== ed || ctrl_o !== ek) begin
      errors++;
      $display("FAIL %s: got %h/%b expected %h/%b", tag, data_o, ctrl_o, ed, ek);
    end
  endtask

  task automatic configure(input logic [1:0] m, input logic [7:0] r, input logic dis);
    pwdn_i = 1'b1; sync_i = 1'b0;
    mode_i = m; rep_cnt_i = r; align_dis_i = dis;
    tick(8'h5A, 1'b0);
    chk(8'h00, 1'b0, "R1 power-down output");
    pwdn_i = 1'b0;
    tick(8'h5A, 1'b0);
    chk(8'hBC, 1'b1, "R2 waiting for sync");
    sync_i = 1'b1;
    tick(8'h5A, 1'b0);
    chk(8'hBC, 1'b1, "R2 sync edge");
  endtask

  // alignment pattern from multiframe 0 position 0
  task automatic chk_seq(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      int p;
      int m;
      logic [7:0] d;
      logic [7:0] ed;
      logic ek;
      p = i % L;
      m = (i / L) % 4;
      d = 8'(i * 3 + 5);
      tick(d, 1'b0);
      ed = d; ek = 1'b0;
      if (p == 0)                begin ed = 8'h1C; ek = 1'b1; end
      else if (p == L - 1)       begin ed = 8'h7C; ek = 1'b1; end
      else if (m == 1 && p == 1) begin ed = 8'h9C; ek = 1'b1; end
      chk(ed, ek, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(8'h00, 1'b0, "R1 reset state");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // mode 01, two sequences; inputs altered afterwards must be ignored (R1)
    configure(2'b01, 8'd1, 1'b0);
    mode_i = 2'b11; rep_cnt_i = 8'd0; align_dis_i = 1'b1;
    chk_seq(4 * L * 2, "R3 R4 two sequences");

    // user data right after: substitution table (R6 R7), disable input ignored (R1)
    for (int v = 0; v < 16; v++) begin
      tick(DVEC[v][17:10], DVEC[v][9]);
      chk(DVEC[v][8:1], DVEC[v][0], "R6 R7 data vector");
    end

    sync_i = 1'b0;
    tick(8'h22, 1'b0);
    chk(8'hBC, 1'b1, "R9 sync lost in data");

    // mode 00 with insertion disabled
    configure(2'b00, 8'd0, 1'b1);
    tick(8'h11, 1'b0); chk(8'h11, 1'b0, "R5 mode 00 no sequence");
    tick(8'h22, 1'b0); chk(8'h22, 1'b0, "R8");
    tick(8'h33, 1'b0); chk(8'h33, 1'b0, "R8");
    tick(8'h22, 1'b0); chk(8'h22, 1'b0, "R8 repeat passes");

    // reserved mode 10 behaves as 00
    configure(2'b10, 8'd3, 1'b0);
    tick(8'h11, 1'b0); chk(8'h11, 1'b0, "R5 mode 10 as 00");

    // endless test mode, count ignored
    configure(2'b11, 8'd0, 1'b0);
    chk_seq(4 * L * 3, "R5 test mode repeats");

    // single sequence with a sync loss inside it
    configure(2'b01, 8'd0, 1'b0);
    chk_seq(L + 2, "R3 partial sequence");
    sync_i = 1'b0;
    tick(8'h5A, 1'b0); chk(8'hBC, 1'b1, "R9 sync lost in sequence");
    sync_i = 1'b1;
    tick(8'h5A, 1'b0); chk(8'hBC, 1'b1, "R2 resync edge");
    chk_seq(4 * L, "R9 restart from multiframe 0");
    tick(8'h11, 1'b0); chk(8'h11, 1'b0, "R4 data after one sequence");
    tick(8'h11, 1'b0); chk(8'h11, 1'b0, "R4 data continues");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule